// File: doc/BRIEF.md
# Single-Level Page Map Translator

This block is a small memory management unit that turns a 12-bit virtual address into an 11-bit physical address. Pages are 256 bytes, so the low eight address bits are carried through unchanged, and the upper four bits select one of sixteen map entries held in on-chip registers. Each entry has a resident flag, a modified flag and a 3-bit physical page number. A lookup that finds its page resident produces a physical address. A lookup that finds its page absent raises a page fault instead.

A fault handler keeps the map up to date through two ports. An update port writes a whole entry for a chosen virtual page. A combinational read port returns any entry, so the handler can tell whether a victim page has been modified before it evicts it. The hardware sets the modified flag itself whenever a store hits a resident page. Lookup results are registered and appear one cycle after the request.

Top module: `page_map_mmu`

## Requirements
- R1: After synchronous reset every entry reads back as not resident, not modified, page number 0, and `pa_valid` and `fault` are low.
- R2: Bits 11:8 of `acc_vaddr` select the entry and bits 7:0 are the page offset. A request to a resident page gives `pa_valid` high one cycle later, with `pa_out` equal to {page number, offset}. For example, virtual 0x2C8 maps to physical 0x4C8 when entry 2 holds page 4.
- R3: A request to a page that is not resident gives `fault` high, `pa_valid` low and `pa_out` zero one cycle later.
- R4: `pa_valid` and `fault` are never high together, and both are low in the cycle after a cycle with no request.
- R5: A store request (`acc_store` high) to a resident page sets that entry's modified flag at the same edge that registers the translation. A load leaves the flag unchanged.
- R6: A store request to a page that is not resident leaves that entry's modified flag clear.
- R7: When `upd_en` is high, the resident flag, modified flag and page number of entry `upd_vpn` take the update values at the clock edge.
- R8: A request and an update to the same page in the same cycle translate with the entry as it was before the update.
- R9: When an update and a store request to a resident page name the same entry in the same cycle, the entry ends with the updated values. The store does not set the modified flag.
- R10: The read port returns, with no clock delay, the current resident flag, modified flag and page number of entry `rd_vpn`.
- R11: An update or a store changes only the entry it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_req | input | 1 | Translation request |
| acc_vaddr | input | 12 | Virtual address |
| acc_store | input | 1 | Request is a store |
| pa_valid | output | 1 | Physical address is valid |
| pa_out | output | 11 | Physical address |
| fault | output | 1 | Page fault for the previous request |
| upd_en | input | 1 | Write an entry |
| upd_vpn | input | 4 | Entry to write |
| upd_resident | input | 1 | New resident flag |
| upd_dirty | input | 1 | New modified flag |
| upd_ppn | input | 3 | New physical page number |
| rd_vpn | input | 4 | Entry to read |
| rd_resident | output | 1 | Resident flag of the read entry |
| rd_dirty | output | 1 | Modified flag of the read entry |
| rd_ppn | output | 3 | Page number of the read entry |

## Verification
The bench targets the same-cycle collisions. A request that meets an update of its own page must use the old mapping, so a design that forwards the new entry would give a valid address where a fault is due, or the reverse. A store that meets an update must lose, so a design with the wrong priority would leave the modified flag set after the handler cleared it. Stores to absent pages must not mark them, and loads must never mark any page. A design that sets the flag without checking residency would report a clean page as needing write-back. A sweep over all sixteen pages with mixed residency checks that the offset is carried through and the page number is chosen by the index, not copied from a neighbouring entry.

// File: rtl/pmm_pkg.sv
// Shared sizes and entry layout for the page map translator.
// Assumes the page offset is the low part of both address forms.
package pmm_pkg;
    localparam int VPN_W     = 4;
    localparam int OFS_W     = 8;
    localparam int PPN_W     = 3;
    localparam int NUM_PAGES = 1 << VPN_W;
    localparam int VA_W      = VPN_W + OFS_W;
    localparam int PA_W      = PPN_W + OFS_W;

    typedef struct packed {
        logic             resident;
        logic             dirty;
        logic [PPN_W-1:0] ppn;
    } pm_entry_t;
endpackage

// File: rtl/pm_entry_file.sv
// Register file of page map entries, one per virtual page.
// Has one write port for the handler, one flag-set port for stores and
// two combinational read ports. A handler write has priority over a
// flag set to the same entry. Reads see the value before the edge.
module pm_entry_file
    import pmm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  pm_entry_t        wr_entry,
    input  logic             set_dirty,
    input  logic [VPN_W-1:0] set_vpn,
    input  logic [VPN_W-1:0] lk_vpn,
    output pm_entry_t        lk_entry,
    input  logic [VPN_W-1:0] rd_vpn,
    output pm_entry_t        rd_entry
);
    pm_entry_t map_q [NUM_PAGES];

    for (genvar i = 0; i < NUM_PAGES; i++) begin : g_entry
        // Hold one entry: reset, handler write, or store marking.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map_q[i] <= '0;
            end else if (wr_en && (wr_vpn == VPN_W'(i))) begin
                map_q[i] <= wr_entry;
            end else if (set_dirty && (set_vpn == VPN_W'(i))) begin
                map_q[i].dirty <= 1'b1;
            end
        end
    end

    // Select the entries for the lookup and handler read ports.
    always_comb begin
        lk_entry = map_q[lk_vpn];
        rd_entry = map_q[rd_vpn];
    end
endmodule

// File: rtl/pm_lookup.sv
// Turns a looked-up entry into a registered translation result.
// Assumes the entry given is the one for the current request's page.
// Asks the entry file to mark the page when a store hits.
module pm_lookup
    import pmm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             store,
    input  logic [OFS_W-1:0] offset,
    input  pm_entry_t        entry,
    output logic             set_dirty,
    output logic             pa_valid,
    output logic             fault,
    output logic [PA_W-1:0]  pa_out
);
    logic hit;

    // Classify the request against the entry.
    always_comb begin
        hit       = req && entry.resident;
        set_dirty = hit && store;
    end

    // Register the translation result or the fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_valid <= 1'b0;
            fault    <= 1'b0;
            pa_out   <= '0;
        end else begin
            pa_valid <= hit;
            fault    <= req && !entry.resident;
            pa_out   <= hit ? {entry.ppn, offset} : '0;
        end
    end
endmodule

// File: rtl/page_map_mmu.sv
// Top of the page map translator: entry file plus lookup stage.
// One request per cycle, result one cycle later. Handler updates and
// reads go directly to the entry file.
module page_map_mmu
    import pmm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_req,
    input  logic [VA_W-1:0]  acc_vaddr,
    input  logic             acc_store,
    output logic             pa_valid,
    output logic [PA_W-1:0]  pa_out,
    output logic             fault,
    input  logic             upd_en,
    input  logic [VPN_W-1:0] upd_vpn,
    input  logic             upd_resident,
    input  logic             upd_dirty,
    input  logic [PPN_W-1:0] upd_ppn,
    input  logic [VPN_W-1:0] rd_vpn,
    output logic             rd_resident,
    output logic             rd_dirty,
    output logic [PPN_W-1:0] rd_ppn
);
    pm_entry_t        wr_entry;
    pm_entry_t        lk_entry;
    pm_entry_t        rd_entry;
    logic             set_dirty;
    logic [VPN_W-1:0] acc_vpn;
    logic [OFS_W-1:0] acc_ofs;

    // Split the address and pack the handler's new entry.
    always_comb begin
        acc_vpn           = acc_vaddr[VA_W-1:OFS_W];
        acc_ofs           = acc_vaddr[OFS_W-1:0];
        wr_entry.resident = upd_resident;
        wr_entry.dirty    = upd_dirty;
        wr_entry.ppn      = upd_ppn;
        rd_resident       = rd_entry.resident;
        rd_dirty          = rd_entry.dirty;
        rd_ppn            = rd_entry.ppn;
    end

    pm_entry_file u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (upd_en),
        .wr_vpn    (upd_vpn),
        .wr_entry  (wr_entry),
        .set_dirty (set_dirty),
        .set_vpn   (acc_vpn),
        .lk_vpn    (acc_vpn),
        .lk_entry  (lk_entry),
        .rd_vpn    (rd_vpn),
        .rd_entry  (rd_entry)
    );

    pm_lookup u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (acc_req),
        .store     (acc_store),
        .offset    (acc_ofs),
        .entry     (lk_entry),
        .set_dirty (set_dirty),
        .pa_valid  (pa_valid),
        .fault     (fault),
        .pa_out    (pa_out)
    );
endmodule

// File: rtl/pmm_checker.sv
// Protocol checks for the page map translator, bound to the top.
// Assumes the lookup entry seen is the entry before the clock edge.
module pmm_checker
    import pmm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             acc_req,
    input logic [VA_W-1:0]  acc_vaddr,
    input logic             pa_valid,
    input logic [PA_W-1:0]  pa_out,
    input logic             fault,
    input logic             lk_res,
    input logic [PPN_W-1:0] lk_ppn
);
    p_translate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && lk_res |=> pa_valid && !fault &&
        (pa_out == {$past(lk_ppn), $past(acc_vaddr[OFS_W-1:0])}));

    p_fault_absent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !lk_res |=> fault && !pa_valid && (pa_out == '0));

    p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(pa_valid && fault));

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> !pa_valid && !fault);
endmodule

bind page_map_mmu pmm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_req   (acc_req),
    .acc_vaddr (acc_vaddr),
    .pa_valid  (pa_valid),
    .pa_out    (pa_out),
    .fault     (fault),
    .lk_res    (lk_entry.resident),
    .lk_ppn    (lk_entry.ppn)
);

// File: tb/test_page_map_mmu.sv
module test_page_map_mmu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_req = 1'b0;
    logic [11:0] acc_vaddr = '0;
    logic        acc_store = 1'b0;
    logic        pa_valid;
    logic [10:0] pa_out;
    logic        fault;
    logic        upd_en = 1'b0;
    logic [3:0]  upd_vpn = '0;
    logic        upd_resident = 1'b0;
    logic        upd_dirty = 1'b0;
    logic [2:0]  upd_ppn = '0;
    logic [3:0]  rd_vpn = '0;
    logic        rd_resident;
    logic        rd_dirty;
    logic [2:0]  rd_ppn;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        int          cyc;
        logic        v;
        logic        f;
        logic [10:0] pa;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic       m_res [16];
    logic       m_dirty [16];
    logic [2:0] m_ppn [16];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    page_map_mmu i_page_map_mmu (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_vaddr(acc_vaddr),
        .acc_store(acc_store), .pa_valid(pa_valid), .pa_out(pa_out),
        .fault(fault), .upd_en(upd_en), .upd_vpn(upd_vpn),
        .upd_resident(upd_resident), .upd_dirty(upd_dirty),
        .upd_ppn(upd_ppn), .rd_vpn(rd_vpn), .rd_resident(rd_resident),
        .rd_dirty(rd_dirty), .rd_ppn(rd_ppn)
    );

    // Monitor: compare each result one cycle after its request.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc < cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (pa_valid !== e.v || fault !== e.f || pa_out !== e.pa) begin
                fails++;
                $display("FAIL %s: got v=%b f=%b pa=%h, expected v=%b f=%b pa=%h",
                         e.tag, pa_valid, fault, pa_out, e.v, e.f, e.pa);
            end
        end
    end

    // Driver: one cycle of stimulus, expected result pushed to the queue.
    task automatic step(input logic rq, input logic [11:0] va, input logic st,
                        input logic we, input logic [3:0] wv, input logic wr,
                        input logic wd, input logic [2:0] wp, input string tag);
        exp_t e;
        logic [3:0] vp;
        @(negedge clk);
        acc_req = rq; acc_vaddr = va; acc_store = st;
        upd_en = we; upd_vpn = wv; upd_resident = wr; upd_dirty = wd; upd_ppn = wp;
        vp = va[11:8];
        e.cyc = cyc; e.tag = tag;
        e.v = rq && m_res[vp];
        e.f = rq && !m_res[vp];
        e.pa = e.v ? {m_ppn[vp], va[7:0]} : 11'h0;
        sb.push_back(e);
        if (we) begin
            m_res[wv] = wr; m_dirty[wv] = wd; m_ppn[wv] = wp;
        end
        if (rq && st && m_res[vp] && !(we && wv == vp)) m_dirty[vp] = 1'b1;
    endtask

    task automatic access(input logic [11:0] va, input logic st, input string tag);
        step(1'b1, va, st, 1'b0, 4'h0, 1'b0, 1'b0, 3'h0, tag);
    endtask

    task automatic put(input logic [3:0] wv, input logic wr, input logic wd,
                       input logic [2:0] wp, input string tag);
        step(1'b0, 12'h0, 1'b0, 1'b1, wv, wr, wd, wp, tag);
    endtask

    task automatic idle();
        step(1'b0, 12'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 3'h0, "R4");
    endtask

    // Read-port check against the bench model, mid low phase.
    task automatic check_entry(input logic [3:0] v, input string tag);
        rd_vpn = v;
        #1;
        checks++;
        if (rd_resident !== m_res[v] || rd_dirty !== m_dirty[v] || rd_ppn !== m_ppn[v]) begin
            fails++;
            $display("FAIL %s: entry %h got r=%b d=%b p=%h, expected r=%b d=%b p=%h",
                     tag, v, rd_resident, rd_dirty, rd_ppn, m_res[v], m_dirty[v], m_ppn[v]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got running, expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_res[i] = 1'b0; m_dirty[i] = 1'b0; m_ppn[i] = 3'h0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: outputs and entries after reset
        checks++;
        if (pa_valid !== 1'b0 || fault !== 1'b0) begin
            fails++;
            $display("FAIL R1: got v=%b f=%b, expected 0 0", pa_valid, fault);
        end
        check_entry(4'h0, "R1");
        check_entry(4'h5, "R1");
        check_entry(4'hF, "R1");

        access(12'h2C8, 1'b0, "R3");
        put(4'h2, 1'b1, 1'b0, 3'h4, "R7");
        idle();
        check_entry(4'h2, "R7");
        access(12'h2C8, 1'b0, "R2");
        idle();
        check_entry(4'h2, "R5");       // load leaves flag clear
        access(12'h2FF, 1'b1, "R5");
        idle();
        check_entry(4'h2, "R5");       // store marks page
        check_entry(4'h3, "R11");

        // R8: update and request to same page in the same cycle
        step(1'b1, 12'h5A0, 1'b0, 1'b1, 4'h5, 1'b1, 1'b0, 3'h7, "R8");
        access(12'h5A0, 1'b0, "R2");
        step(1'b1, 12'h201, 1'b0, 1'b1, 4'h2, 1'b0, 1'b0, 3'h4, "R8");
        access(12'h201, 1'b0, "R3");

        // R9: update beats a store to the same page
        put(4'h9, 1'b1, 1'b0, 3'h3, "R7");
        step(1'b1, 12'h910, 1'b1, 1'b1, 4'h9, 1'b1, 1'b0, 3'h6, "R9");
        idle();
        check_entry(4'h9, "R9");
        check_entry(4'h5, "R11");

        // R6: store to an absent page
        access(12'hC44, 1'b1, "R6");
        idle();
        check_entry(4'hC, "R6");

        // Sweep: mixed residency across all pages
        for (int i = 0; i < 16; i++)
            put(4'(i), (i % 3) != 0, 1'b0, 3'((i * 5 + 1) & 7), "R7");
        for (int i = 0; i < 16; i++)
            access({4'(i), 8'(i * 17 + 3)}, 1'b0, (i % 3) != 0 ? "R2" : "R3");
        for (int i = 0; i < 16; i++) begin
            access({4'(i), 8'hFF - 8'(i)}, 1'b1, "R5");
            idle();
        end
        for (int i = 0; i < 16; i++) check_entry(4'(i), "R10");

        idle();
        idle();
        @(negedge clk);
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule